// File: doc/BRIEF.md
# Decimal-Programmable Four-Ratio Divider

This block divides a fast clock by a ratio set as three decimal digits: a hundreds count, a tens count and a units count. Internally, a prescaler divides the fast clock by one of four ratios: the base, the base plus ten, the base plus one, or the base plus eleven. Two nonzero flags choose the ratio. One flag comes from the tens counter and the other from the units counter. Every prescaler cycle steps all three counters. The tens and units counters stop once they reach zero. When the hundreds counter runs out, all three counters reload from their presets and the block emits one output pulse. The spacing of those pulses is therefore 100·H + 10·T + U fast-clock cycles.

The digit radix is a parameter. With radix r, the four prescaler ratios are r², r²+r, r²+1 and r²+r+1, and the total ratio is r²·H + r·T + U. The prescaler event is also brought out as a pin, so a phase detector or an observer can follow the inner cycle. The hundreds preset must be at least 1 and no smaller than either of the other two digits. The tens and units presets range from 0 to r−1.

Top module: `quad_mod_divider`

## Requirements
- R1: With presets H, T and U, successive `div_pulse` pulses are exactly r²·H + r·T + U clock cycles apart, where r = RADIX (10 by default, giving 100·H + 10·T + U).
- R2: Each prescaler cycle lasts r², r²+1, r²+r or r²+r+1 clocks. The cycle adds r when the tens counter is nonzero and adds 1 when the units counter is nonzero. A `pre_tick` pulse marks the end of each prescaler cycle.
- R3: Number the prescaler cycles of a period 0 to H−1. Cycle k adds r exactly when k < T and adds 1 exactly when k < U. With H=10, T=2 and U=3, the cycle lengths are 111, 111, 101 and then 100 seven times.
- R4: The hundreds counter steps down at every prescaler event. At the event that empties it, all three counters reload from the presets. `div_pulse` rises together with the `pre_tick` that closes the period, and at no other time.
- R5: `div_pulse` and `pre_tick` are each high for exactly one clock cycle per event.
- R6: Reset is synchronous and active high. While it is applied, both outputs are low and the counters hold their presets. The first `pre_tick` comes after a full prescaler cycle, and the first `div_pulse` comes after the full total ratio, counted in rising edges from the first edge with reset low.
- R7: The RADIX parameter scales the scheme. For example, radix 3 gives prescaler ratios 9, 10, 12 and 13 and a total of 9·H + 3·T + U.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| hund_preset | input | N1W | Hundreds digit preset H (at least 1) |
| tens_preset | input | DW | Tens digit preset T (0 to RADIX−1) |
| unit_preset | input | DW | Units digit preset U (0 to RADIX−1) |
| pre_tick | output | 1 | One-cycle pulse at the end of each prescaler cycle |
| div_pulse | output | 1 | One-cycle pulse at the end of each full division period |

## Verification
A radix-3 instance is run through every legal preset triple. This sweep separates presets where the tens digit runs out before the units digit from the reverse order, and from ties where both are equal. Triples with the hundreds digit equal to a lower digit exercise the case where all flags stay set until the reload event. The default radix-10 instance is tried with the worked triple 10/2/3 and with the extremes 1/0/0, 1/1/1, 9/9/9 and 15/9/9. It is also tried with 12/0/5, where only the units flag is ever set. Every prescaler interval is compared against the closed form k < T, k < U, and each full period against the weighted digit sum. Each configuration runs for two periods, which shows that the reload restores the same sequence.

// File: rtl/qmod_pkg.sv
package qmod_pkg;

  // Length of one prescaler cycle for the given flag pair.
  function automatic int unsigned presc_len(input int unsigned radix,
                                            input logic tens_nz,
                                            input logic unit_nz);
    return radix * radix + (tens_nz ? radix : 0) + (unit_nz ? 1 : 0);
  endfunction

  // Full division ratio for a preset triple.
  function automatic int unsigned total_len(input int unsigned radix,
                                            input int unsigned hund,
                                            input int unsigned tens,
                                            input int unsigned unit);
    return radix * radix * hund + radix * tens + unit;
  endfunction

endpackage

// File: rtl/qmod_prescaler.sv
module qmod_prescaler #(
  parameter int unsigned RADIX = 10,
  parameter int unsigned PW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tens_nz,
  input  logic          unit_nz,
  output logic          tick,
  output logic [PW-1:0] cnt
);
  import qmod_pkg::*;

  logic [PW-1:0] last_val;

  // Flags only change at a tick, so the selected length is constant for a cycle.
  always_comb begin
    last_val = PW'(presc_len(RADIX, tens_nz, unit_nz) - 1);
    tick     = (cnt == last_val);
  end

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/qmod_down_cnt.sv
module qmod_down_cnt #(
  parameter int unsigned W         = 4,
  parameter bit          HOLD_ZERO = 1'b1
) (
  input  logic         clk,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] preset,
  output logic [W-1:0] value,
  output logic         nz
);
  assign nz = (value != '0);

  generate
    if (HOLD_ZERO) begin : g_hold
      always_ff @(posedge clk) begin
        if (load)            value <= preset;
        else if (step && nz) value <= value - W'(1);
      end
    end else begin : g_free
      always_ff @(posedge clk) begin
        if (load)      value <= preset;
        else if (step) value <= value - W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/quad_mod_divider.sv
module quad_mod_divider #(
  parameter int unsigned RADIX = 10,
  parameter int unsigned N1W   = 4,
  parameter int unsigned DW    = $clog2(RADIX),
  parameter int unsigned PW    = $clog2(RADIX * RADIX + RADIX + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N1W-1:0] hund_preset,
  input  logic [DW-1:0]  tens_preset,
  input  logic [DW-1:0]  unit_preset,
  output logic           pre_tick,
  output logic           div_pulse
);
  localparam int unsigned NDIG = 2;

  // Named internal events for the checker.
  logic           pre_evt;
  logic           wrap_evt;
  logic           load_all;
  logic [PW-1:0]  pre_cnt;
  logic [N1W-1:0] hund_q;
  logic           hund_nz;
  logic [DW-1:0]  dig_q   [NDIG];
  logic           dig_nz  [NDIG];
  logic [DW-1:0]  dig_pre [NDIG];

  assign dig_pre[0] = tens_preset;
  assign dig_pre[1] = unit_preset;

  assign wrap_evt = pre_evt && (hund_q <= N1W'(1));
  assign load_all = rst || wrap_evt;

  qmod_prescaler #(.RADIX(RADIX), .PW(PW)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .tens_nz (dig_nz[0]),
    .unit_nz (dig_nz[1]),
    .tick    (pre_evt),
    .cnt     (pre_cnt)
  );

  qmod_down_cnt #(.W(N1W), .HOLD_ZERO(1'b0)) u_hund (
    .clk    (clk),
    .load   (load_all),
    .step   (pre_evt),
    .preset (hund_preset),
    .value  (hund_q),
    .nz     (hund_nz)
  );

  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
      qmod_down_cnt #(.W(DW), .HOLD_ZERO(1'b1)) u_dig (
        .clk    (clk),
        .load   (load_all),
        .step   (pre_evt),
        .preset (dig_pre[g]),
        .value  (dig_q[g]),
        .nz     (dig_nz[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_tick  <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      pre_tick  <= pre_evt;
      div_pulse <= wrap_evt;
    end
  end
endmodule

module qmod_checker #(
  parameter int unsigned RADIX = 10,
  parameter int unsigned N1W   = 4,
  parameter int unsigned DW    = 4,
  parameter int unsigned PW    = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           pre_evt,
  input logic           wrap_evt,
  input logic [PW-1:0]  pre_cnt,
  input logic [N1W-1:0] hund_q,
  input logic [N1W-1:0] hund_preset,
  input logic [DW-1:0]  tens_q,
  input logic [DW-1:0]  unit_q,
  input logic           pre_tick,
  input logic           div_pulse
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R6
  always_ff @(posedge clk) begin
    if (rst_seen) reset_quiet_chk: assert (!pre_tick && !div_pulse);
  end

  // R4
  div_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> pre_tick);

  // R4
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> hund_q == $past(hund_preset));

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_evt && !wrap_evt && unit_q != '0) |=> unit_q == $past(unit_q) - DW'(1));

  // R3
  tens_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pre_evt |=> $stable(tens_q) && $stable(unit_q) && $stable(hund_q));

  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PW'(RADIX * RADIX + RADIX));

  // R5
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    pre_tick |=> !pre_tick);
endmodule

bind quad_mod_divider qmod_checker #(
  .RADIX(RADIX), .N1W(N1W), .DW(DW), .PW(PW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pre_evt     (pre_evt),
  .wrap_evt    (wrap_evt),
  .pre_cnt     (pre_cnt),
  .hund_q      (hund_q),
  .hund_preset (hund_preset),
  .tens_q      (dig_q[0]),
  .unit_q      (dig_q[1]),
  .pre_tick    (pre_tick),
  .div_pulse   (div_pulse)
);

// File: tb/sim_quad_mod_divider.sv
`timescale 1ns/1ps
module sim_quad_mod_divider;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // u0: default radix 10
  logic       rst0 = 1'b1;
  logic [3:0] h0 = 4'd1, t0 = 4'd0, u0p = 4'd0;
  logic       pt0, dv0;
  quad_mod_divider u0 (
    .clk(clk), .rst(rst0), .hund_preset(h0), .tens_preset(t0),
    .unit_preset(u0p), .pre_tick(pt0), .div_pulse(dv0));

  // u1: radix 3, swept exhaustively
  logic       rst1 = 1'b1;
  logic [2:0] h1 = 3'd1;
  logic [1:0] t1 = 2'd0, u1p = 2'd0;
  logic       pt1, dv1;
  quad_mod_divider #(.RADIX(3), .N1W(3)) u1 (
    .clk(clk), .rst(rst1), .hund_preset(h1), .tens_preset(t1),
    .unit_preset(u1p), .pre_tick(pt1), .div_pulse(dv1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cfg(input int sel, input int p1, input int p2, input int p3);
    int r, tot, since, sinced, k, periods, guard, elen;
    bit pt, dv, etk, edv;
    string sfx;
    r   = (sel == 0) ? 10 : 3;
    sfx = (sel == 0) ? "" : " R7";
    tot = r * r * p1 + r * p2 + p3;
    @(negedge clk);
    if (sel == 0) begin rst0 = 1'b1; h0 = 4'(p1); t0 = 4'(p2); u0p = 4'(p3); end
    else          begin rst1 = 1'b1; h1 = 3'(p1); t1 = 2'(p2); u1p = 2'(p3); end
    repeat (2) @(negedge clk);
    pt = (sel == 0) ? pt0 : pt1;
    dv = (sel == 0) ? dv0 : dv1;
    chk(!pt && !dv, "R6 outputs low in reset", int'(pt) + int'(dv), 0);
    if (sel == 0) rst0 = 1'b0; else rst1 = 1'b0;
    since = 0; sinced = 0; k = 0; periods = 0; guard = 0;
    while (periods < 2 && guard < 2 * tot + 50) begin
      @(posedge clk);
      since++; sinced++; guard++;
      @(negedge clk);
      pt   = (sel == 0) ? pt0 : pt1;
      dv   = (sel == 0) ? dv0 : dv1;
      elen = r * r + ((k < p2) ? r : 0) + ((k < p3) ? 1 : 0);
      etk  = (since == elen);
      edv  = etk && (k == p1 - 1);
      chk(pt == etk, $sformatf("R2 R3 R5 tick k=%0d cfg %0d/%0d/%0d%s", k, p1, p2, p3, sfx),
          int'(pt), int'(etk));
      chk(dv == edv, $sformatf("R4 R5 div k=%0d cfg %0d/%0d/%0d%s", k, p1, p2, p3, sfx),
          int'(dv), int'(edv));
      if (etk) begin
        since = 0;
        if (k == p1 - 1) begin
          chk(sinced == tot, $sformatf("R1 R6 period cfg %0d/%0d/%0d%s", p1, p2, p3, sfx),
              sinced, tot);
          sinced = 0; k = 0; periods++;
        end else k++;
      end
    end
    chk(periods == 2, "R1 two periods reached", periods, 2);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3 worked triple; R1 extremes
    run_cfg(0, 10, 2, 3);
    run_cfg(0, 1, 0, 0);
    run_cfg(0, 1, 1, 1);
    run_cfg(0, 9, 9, 9);
    run_cfg(0, 15, 9, 9);
    run_cfg(0, 12, 0, 5);
    // R7 exhaustive radix-3 sweep of legal triples
    for (int a = 1; a < 8; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          if (a >= b && a >= c) run_cfg(1, a, b, c);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule